// File: doc/BRIEF.md
# Paged Three-Wire Register Bus Master

This block drives a three-wire register bus as its host. The bus has a clock line, one bidirectional data line and a direction line: high while the host drives data and low while the peripheral does. A client sends one byte-wide register write or read per command through a valid/ready port that carries a logical address and write data. Read results come back as a one-cycle pulse on a response port.

The peripheral's registers are split across two pages, and a page-select register picks one of them. The block keeps a cached copy of the selected page. When a command targets the other page, or when no page has been selected since reset, it first sends its own write transfer to the page-select register. It then updates the cache, waits one bit delay, and runs the requested transfer. Two registers get their write data rewritten before it is sent: a capacitor-bank register, whose value is mirrored into a physical code, and a control register that has three bits that must always read as one.

The bus timing comes from a half-period counter of `BIT_DLY` system clock cycles. Every level of the bus clock, the settle period at the start of a write phase and the gap after a page switch each last exactly that long.

Top module: `tw_page_master`

## Requirements
- R1: When idle after reset, the bus clock is high, the direction line is low, the data driver is disabled and `cmd_ready` is high.
- R2: A write sends 16 bits with the direction line high: the data byte first, then the physical address byte, each byte least-significant bit first. The data line changes only while the bus clock is low, and the peripheral samples it on the rising edge.
- R3: Logical addresses of 0x10 and above select page code 0x02 and are sent as the address minus 0x10. Lower addresses select page code 0x01 and are sent unchanged.
- R4: If the target page differs from the cached page, or the cache is empty after reset, a write of the page code to physical address `PSEL_ADDR` (default 0x01) is sent first. Accesses that follow on the same page send no page-select transfer.
- R5: Write data for logical address `CAP_ADDR` (default 0x07) is sent as 255 minus the value when the value is below 64, and as 191 minus the value otherwise.
- R6: Write data for logical address `FORCE_ADDR` (default 0x16) is sent with bits 4, 1 and 0 set to one.
- R7: A read sends the 8-bit physical address with the direction line high. It then releases the data line, drops the direction line and runs eight bus clock pulses. The data line is sampled at the end of each low level and assembled least-significant bit first. The result appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R8: Every bus clock level, the settle delay at the start of a write phase and the gap after a page switch each last `BIT_DLY` cycles. `cmd_ready` stays low from accept until the transfer has fully ended. From accept to ready, a write or read takes 33×`BIT_DLY` cycles, or 67×`BIT_DLY` cycles when a page switch is added.
- R9: The data driver is enabled exactly while the direction line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_addr | input | 8 | Logical register address |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| bus_clk | output | 1 | Bus clock line |
| bus_dir | output | 1 | Direction line, high while the host drives data |
| bus_data_oe | output | 1 | Data line driver enable |
| bus_data_o | output | 1 | Data line value when driven |
| bus_data_i | input | 1 | Data line value seen at the pad |

## Verification
Each command is accepted on one clock edge. With `BIT_DLY` = D, `cmd_ready` comes back, and for a read `rsp_valid` pulses, exactly 33·D edges later, or 67·D edges later when a page switch comes first. After accept, the bench counts falling clock edges until ready returns and compares that count with the figure it works out from its own model of the page cache. Bus frames are collected on the rising edges of the bus clock and closed on the falling edge of the direction line. The frames are compared only after ready returns, so the order of events within a clock edge cannot change a result. The bench's bus model drives read data on each falling edge of the bus clock, a full half period before the block samples it.

// File: rtl/twb_pkg.sv
package twb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BLO,
    ST_BHI,
    ST_GAP,
    ST_RLO,
    ST_RHI
  } st_e;

  // capacitor code mirror: low band folds from 255, upper band from 191
  function automatic logic [7:0] cap_code(input logic [7:0] v);
    return (v < 8'd64) ? (8'd255 - v) : (8'd191 - v);
  endfunction

  function automatic logic [7:0] force_ones(input logic [7:0] v, input logic [7:0] m);
    return v | m;
  endfunction

endpackage

// File: rtl/twb_addr_map.sv
module twb_addr_map #(
  parameter logic [7:0] PAGE_BASE  = 8'h10,
  parameter logic [7:0] PAGE1_CODE = 8'h01,
  parameter logic [7:0] PAGE2_CODE = 8'h02,
  parameter logic [7:0] CAP_ADDR   = 8'h07,
  parameter logic [7:0] FORCE_ADDR = 8'h16,
  parameter logic [7:0] FORCE_MASK = 8'h13
) (
  input  logic [7:0] log_addr,
  input  logic [7:0] log_data,
  output logic [7:0] page_code,
  output logic [7:0] phys_addr,
  output logic [7:0] tx_data
);
  logic upper;
  assign upper     = (log_addr >= PAGE_BASE);
  assign page_code = upper ? PAGE2_CODE : PAGE1_CODE;
  assign phys_addr = upper ? (log_addr - PAGE_BASE) : log_addr;

  always_comb begin
    if (log_addr == CAP_ADDR)        tx_data = twb_pkg::cap_code(log_data);
    else if (log_addr == FORCE_ADDR) tx_data = twb_pkg::force_ones(log_data, FORCE_MASK);
    else                             tx_data = log_data;
  end
endmodule

// File: rtl/twb_half_timer.sv
module twb_half_timer #(
  parameter int BIT_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic expired
);
  localparam int CW = (BIT_DLY < 2) ? 1 : $clog2(BIT_DLY);
  localparam logic [CW-1:0] LAST = CW'(BIT_DLY - 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R8: the counter never runs past the programmed half period
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/tw_page_master.sv
module tw_page_master #(
  parameter int         BIT_DLY    = 4,
  parameter logic [7:0] PAGE_BASE  = 8'h10,
  parameter logic [7:0] PAGE1_CODE = 8'h01,
  parameter logic [7:0] PAGE2_CODE = 8'h02,
  parameter logic [7:0] PSEL_ADDR  = 8'h01,
  parameter logic [7:0] CAP_ADDR   = 8'h07,
  parameter logic [7:0] FORCE_ADDR = 8'h16,
  parameter logic [7:0] FORCE_MASK = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_write,
  input  logic [7:0] cmd_addr,
  input  logic [7:0] cmd_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       bus_clk,
  output logic       bus_dir,
  output logic       bus_data_oe,
  output logic       bus_data_o,
  input  logic       bus_data_i
);
  import twb_pkg::*;

  localparam int         FW       = 16;
  localparam logic [3:0] LAST_WR  = 4'd15;
  localparam logic [3:0] LAST_ADR = 4'd7;

  st_e        state;
  logic [7:0] req_addr, req_data;
  logic       req_write;
  logic       in_page_xfer;
  logic       cache_valid;
  logic [7:0] cache_page;
  logic [FW-1:0] sh;
  logic [3:0] bitcnt, last_bit;
  logic [7:0] rd_sh;

  // named internal events for the checks
  logic tick, accept, frame_done, page_xfer_done, rd_sample, rd_done, need_switch;

  logic [7:0] map_addr, map_data, pg_code, ph_addr, tx_data;

  assign map_addr = (state == ST_IDLE) ? cmd_addr  : req_addr;
  assign map_data = (state == ST_IDLE) ? cmd_wdata : req_data;

  twb_addr_map #(
    .PAGE_BASE(PAGE_BASE), .PAGE1_CODE(PAGE1_CODE), .PAGE2_CODE(PAGE2_CODE),
    .CAP_ADDR(CAP_ADDR), .FORCE_ADDR(FORCE_ADDR), .FORCE_MASK(FORCE_MASK)
  ) u_map (
    .log_addr (map_addr),
    .log_data (map_data),
    .page_code(pg_code),
    .phys_addr(ph_addr),
    .tx_data  (tx_data)
  );

  logic tmr_exp;
  twb_half_timer #(.BIT_DLY(BIT_DLY)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state == ST_IDLE || tick),
    .expired(tmr_exp)
  );

  assign tick           = tmr_exp && (state != ST_IDLE);
  assign cmd_ready      = (state == ST_IDLE);
  assign accept         = cmd_valid && cmd_ready;
  assign need_switch    = !cache_valid || (cache_page != pg_code);
  assign frame_done     = tick && (state == ST_BHI) && (bitcnt == last_bit);
  assign page_xfer_done = frame_done && in_page_xfer;
  assign rd_sample      = tick && (state == ST_RLO);
  assign rd_done        = tick && (state == ST_RHI) && (bitcnt == 4'd7);

  // bus outputs decoded from the state register
  assign bus_clk     = !(state == ST_BLO || state == ST_RLO);
  assign bus_dir     = (state == ST_START || state == ST_BLO || state == ST_BHI);
  assign bus_data_oe = bus_dir;
  assign bus_data_o  = bus_dir & sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      req_addr     <= '0;
      req_data     <= '0;
      req_write    <= 1'b0;
      in_page_xfer <= 1'b0;
      cache_valid  <= 1'b0;
      cache_page   <= '0;
      sh           <= '0;
      bitcnt       <= '0;
      last_bit     <= '0;
      rd_sh        <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          req_addr  <= cmd_addr;
          req_data  <= cmd_wdata;
          req_write <= cmd_write;
          bitcnt    <= '0;
          state     <= ST_START;
          if (need_switch) begin
            in_page_xfer <= 1'b1;
            sh           <= {PSEL_ADDR, pg_code};
            last_bit     <= LAST_WR;
            cache_page   <= pg_code;
          end else begin
            in_page_xfer <= 1'b0;
            sh           <= cmd_write ? {ph_addr, tx_data} : {8'h00, ph_addr};
            last_bit     <= cmd_write ? LAST_WR : LAST_ADR;
          end
        end
        ST_START: if (tick) state <= ST_BLO;
        ST_BLO:   if (tick) state <= ST_BHI;
        ST_BHI: if (tick) begin
          sh     <= sh >> 1;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt != last_bit)  state <= ST_BLO;
          else if (in_page_xfer) begin
            cache_valid <= 1'b1;
            state       <= ST_GAP;
          end else if (!req_write) begin
            bitcnt <= '0;
            state  <= ST_RLO;
          end else state <= ST_IDLE;
        end
        ST_GAP: if (tick) begin
          in_page_xfer <= 1'b0;
          bitcnt       <= '0;
          sh           <= req_write ? {ph_addr, tx_data} : {8'h00, ph_addr};
          last_bit     <= req_write ? LAST_WR : LAST_ADR;
          state        <= ST_START;
        end
        ST_RLO: if (tick) begin
          rd_sh[bitcnt[2:0]] <= bus_data_i;
          state              <= ST_RHI;
        end
        ST_RHI: if (tick) begin
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 4'd7) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_sh;
            state     <= ST_IDLE;
          end else state <= ST_RLO;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: whenever a command can be taken the bus rests in its idle levels
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bus_clk && !bus_dir && !bus_data_oe));

  // R2: data only moves while the bus clock is low
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dir && bus_clk && $past(bus_dir) && $past(bus_clk)) |-> $stable(bus_data_o));

  // R4: a finished page-select transfer leaves a valid cache
  p_cache_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_xfer_done |=> cache_valid);

  // R7: read response is a single-cycle pulse, sampling happens with the line released
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rd_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |-> (!bus_data_oe && !bus_clk));

  // R8: no new command while a write phase is on the wire
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dir |-> !cmd_ready);

  // R9: driver enable tracks the direction line
  p_oe_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe == bus_dir);

endmodule

// File: tb/tb_tw_page_master.sv
`timescale 1ns/1ps
module tb_tw_page_master;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic cmd_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic bus_clk, bus_dir, bus_data_oe, bus_data_o;
  logic bus_data_i = 1'b0;

  always #2 clk = ~clk;

  tw_page_master #(.BIT_DLY(D)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_clk(bus_clk), .bus_dir(bus_dir), .bus_data_oe(bus_data_oe),
    .bus_data_o(bus_data_o), .bus_data_i(bus_data_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus-side model: frame capture and read data source
  logic [15:0] cap_val = '0;
  int cap_n = 0;
  logic [15:0] fq_val[$];
  int fq_n[$];
  logic [7:0] slv_val = '0;
  int ridx = 0;

  always @(posedge bus_dir) begin cap_val = '0; cap_n = 0; end
  always @(posedge bus_clk) if (rst_n && bus_dir === 1'b1) begin
    if (cap_n < 16) cap_val[cap_n] = bus_data_o;
    cap_n++;
  end
  always @(negedge bus_dir) if (rst_n) begin
    fq_val.push_back(cap_val); fq_n.push_back(cap_n); ridx = 0;
  end
  always @(negedge bus_clk) if (rst_n && bus_dir === 1'b0) begin
    if (ridx < 8) bus_data_i = slv_val[ridx];
    ridx++;
  end

  // bench reference of the page cache (0 = nothing selected)
  int bpage = 0;

  function automatic int pg_of(input logic [7:0] a);
    return (a < 8'd16) ? 1 : 2;
  endfunction
  function automatic logic [7:0] ph_of(input logic [7:0] a);
    return (a < 8'd16) ? a : a - 8'd16;
  endfunction
  function automatic logic [7:0] exp_tx(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h07) return (d < 8'd64) ? ~d : 8'd191 - d;
    if (a == 8'h16) return {d[7:5], 1'b1, d[3:2], 2'b11};
    return d;
  endfunction

  task automatic issue(input logic w, input logic [7:0] a, input logic [7:0] d, output int n);
    fq_val.delete(); fq_n.delete();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!cmd_ready) begin @(negedge clk); n++; end
  endtask

  task automatic check_switch(input string tag, input logic [7:0] a, input int n, input int base, output int idx);
    bit sw;
    sw = (bpage != pg_of(a));
    chk({tag, " R8 duration"}, n, sw ? 67*D : base*D);
    chk({tag, " R4 frame count"}, fq_val.size(), sw ? 2 : 1);
    idx = 0;
    if (sw && fq_val.size() == 2) begin
      chk({tag, " R4/R3 page-select frame"}, fq_val[0], {8'h01, 8'(pg_of(a))});
      chk({tag, " R4 page-select bits"}, fq_n[0], 16);
      idx = 1;
    end
    bpage = pg_of(a);
  endtask

  task automatic t_write(input string tag, input logic [7:0] a, input logic [7:0] d);
    int n, idx;
    issue(1'b1, a, d, n);
    check_switch(tag, a, n, 33, idx);
    if (fq_val.size() > idx) begin
      chk({tag, " R2 write frame"}, fq_val[idx], {ph_of(a), exp_tx(a, d)});
      chk({tag, " R2 write bits"}, fq_n[idx], 16);
    end
  endtask

  task automatic t_read(input string tag, input logic [7:0] a, input logic [7:0] v);
    int n, idx;
    slv_val = v;
    issue(1'b0, a, 8'h00, n);
    chk({tag, " R7 rsp_valid"}, rsp_valid, 1'b1);
    chk({tag, " R7 rsp_rdata"}, rsp_rdata, v);
    check_switch(tag, a, n, 33, idx);
    if (fq_val.size() > idx) begin
      chk({tag, " R7 address frame"}, fq_val[idx][7:0], ph_of(a));
      chk({tag, " R7 address bits"}, fq_n[idx], 8);
    end
    @(negedge clk);
    chk({tag, " R7 pulse ends"}, rsp_valid, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 bus_clk", bus_clk, 1'b1);
    chk("R1 bus_dir", bus_dir, 1'b0);
    chk("R9 oe idle", bus_data_oe, 1'b0);
    chk("R1 ready", cmd_ready, 1'b1);
    chk("R7 rsp idle", rsp_valid, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write("first access R4", 8'h03, 8'hA5);
    t_write("same page", 8'h05, 8'h3C);
    t_write("page2 R3", 8'h12, 8'h5A);
    t_write("forced bits R6", 8'h16, 8'h40);
    t_write("cap low R5", 8'h07, 8'd10);
    t_write("cap edge63 R5", 8'h07, 8'd63);
    t_write("cap edge64 R5", 8'h07, 8'd64);
    t_write("cap high R5", 8'h07, 8'd191);
    t_read("read page1", 8'h0A, 8'hC6);
    t_read("read page2 R3", 8'h1D, 8'h39);
    t_read("read same page", 8'h10, 8'h81);
    t_reset();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule